// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block turns the peripheral clock into the bit timing of a serial master. A first stage divides by an even prescale value. A second stage then counts a programmable number of those ticks. Together they mark every half period of the serial clock. On each half period the block flips a registered serial clock level. It also raises a one-cycle strobe. That strobe tells the shifter either to capture incoming data or to launch the next outgoing bit.

The shifter asserts a run request for as long as it has bits to move. Software sets the global enable. When either of these is low, both counter stages clear, no strobe fires, and the serial clock rests at the level chosen by the polarity input. The phase input picks which edge of each bit is the capture edge.

Top module: `sclk_divider`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both strobes are low and `sclk` equals `cpol`.
- R2: While `en` or `run` is low, both strobes stay low and `sclk` equals `cpol` from the next cycle on. Holding `run` high while `en` is low has no effect.
- R3: Let `en` and `run` be high together, starting at a clock edge. The first edge strobe appears H cycles later, and every following one comes H cycles after the one before. H = P/2 × (`rate` + 1), where P is the effective prescale value.
- R4: The effective prescale value ignores bit 0 of `presc`, so an odd value acts as the even value just below it. A value of 0 or 1 acts as 2.
- R5: On the cycle in which a strobe is high, `sclk` has just changed level. The first edge after activation moves `sclk` away from `cpol`, and the edges then alternate.
- R6: Counting edges from 1 after activation, odd edges are leading and even edges are trailing. With `cpha` = 0, `sample_stb` marks leading edges and `shift_stb` marks trailing edges. With `cpha` = 1 the two are swapped.
- R7: Each strobe lasts one cycle per edge, and `sample_stb` and `shift_stb` are never high together.
- R8: If activation is dropped in the middle of a bit and then restored, timing starts again from zero. The first edge again comes H cycles after the restart and is again a leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| run | input | 1 | Transfer request from the shifter |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| presc | input | PRE_W (8) | First-stage divisor, even, 2 to 254 |
| rate | input | RATE_W (8) | Second-stage divisor minus one |
| sclk | output | 1 | Serial clock level |
| sample_stb | output | 1 | One-cycle capture-edge strobe |
| shift_stb | output | 1 | One-cycle launch-edge strobe |

## Verification
The assertions assume that `presc`, `rate`, `cpol` and `cpha` stay constant while `en` and `run` are both high. The spacing and toggle checks compare against the live configuration, so a change in the middle of a transfer would show up as a false violation. The bench changes the configuration only while the block is idle. It draws the settings from a seeded `$urandom` and adds directed corner cases: the extreme prescale values, odd prescale values, the largest divider, a run request while disabled, and a restart in the middle of a bit.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

   typedef enum logic { EDGE_LEAD = 1'b0, EDGE_TRAIL = 1'b1 } edge_kind_e;

   // Half of the effective (even, >= 2) prescale value.
   function automatic int unsigned half_presc(input int unsigned p);
      int unsigned h;
      h = p >> 1;
      return (h == 0) ? 1 : h;
   endfunction

endpackage

// File: rtl/sclkdiv_prescaler.sv
module sclkdiv_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [PRE_W-1:0] presc,
   output logic             tick
);
   localparam int HW = PRE_W - 1;

   logic [HW-1:0] half;
   logic [HW-1:0] cnt_q;

   // Bit 0 dropped; a zero half clamps to one (divide by two).
   always_comb begin
      half = presc[PRE_W-1:1];
      if (half == '0) half = HW'(1);
   end

   assign tick = active && (cnt_q == half - HW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!active || tick)  cnt_q <= '0;
      else                       cnt_q <= cnt_q + HW'(1);
   end

endmodule

// File: rtl/sclkdiv_rate.sv
module sclkdiv_rate #(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tick,
   input  logic [RATE_W-1:0] rate,
   output logic              edge_now
);
   logic [RATE_W-1:0] cnt_q;

   assign edge_now = tick && (cnt_q == rate);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!active)    cnt_q <= '0;
      else if (edge_now)   cnt_q <= '0;
      else if (tick)       cnt_q <= cnt_q + RATE_W'(1);
   end

endmodule

// File: rtl/sclkdiv_edge.sv
module sclkdiv_edge
   import sclkdiv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic edge_now,
   input  logic cpol,
   input  logic cpha,
   output logic sclk,
   output logic sample_stb,
   output logic shift_stb
);
   logic       tog_q;
   logic       samp_q;
   logic       shft_q;
   edge_kind_e kind;
   logic       capture;

   // tog_q == 0: clock rests at idle, so the coming edge is leading.
   assign kind    = tog_q ? EDGE_TRAIL : EDGE_LEAD;
   assign capture = (kind == EDGE_LEAD) ? ~cpha : cpha;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q  <= 1'b0;
         samp_q <= 1'b0;
         shft_q <= 1'b0;
      end else if (!active) begin
         tog_q  <= 1'b0;
         samp_q <= 1'b0;
         shft_q <= 1'b0;
      end else begin
         samp_q <= edge_now &&  capture;
         shft_q <= edge_now && !capture;
         if (edge_now) tog_q <= ~tog_q;
      end
   end

   assign sclk       = tog_q ^ cpol;
   assign sample_stb = samp_q;
   assign shift_stb  = shft_q;

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider #(
   parameter int PRE_W  = 8,
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              run,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [PRE_W-1:0]  presc,
   input  logic [RATE_W-1:0] rate,
   output logic              sclk,
   output logic              sample_stb,
   output logic              shift_stb
);
   generate
      if (PRE_W < 2) begin : g_bad_pre
         $error("sclk_divider: PRE_W must be at least 2");
      end
      if (RATE_W < 1) begin : g_bad_rate
         $error("sclk_divider: RATE_W must be at least 1");
      end
   endgenerate

   logic active;
   logic tick;
   logic edge_now;

   assign active = en && run;

   sclkdiv_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .active(active), .presc(presc), .tick(tick)
   );

   sclkdiv_rate #(.RATE_W(RATE_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(tick),
      .rate(rate), .edge_now(edge_now)
   );

   sclkdiv_edge u_edge (
      .clk(clk), .rst_n(rst_n), .active(active), .edge_now(edge_now),
      .cpol(cpol), .cpha(cpha), .sclk(sclk),
      .sample_stb(sample_stb), .shift_stb(shift_stb)
   );

endmodule

// File: rtl/sclk_divider_chk.sv
module sclk_divider_chk #(
   parameter int PRE_W  = 8,
   parameter int RATE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              run,
   input logic              cpol,
   input logic              cpha,
   input logic [PRE_W-1:0]  presc,
   input logic [RATE_W-1:0] rate,
   input logic              sclk,
   input logic              sample_stb,
   input logic              shift_stb
);
   localparam int CW = PRE_W + RATE_W + 1;

   logic          act;
   logic          stb;
   logic [CW-1:0] gap_q;
   logic [CW-1:0] h_exp;

   assign act   = en && run;
   assign stb   = sample_stb || shift_stb;
   assign h_exp = CW'(sclkdiv_pkg::half_presc(int'(presc))) * (CW'(rate) + CW'(1));

   // Cycles since activation or since the previous strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gap_q <= '0;
      else if (!act)    gap_q <= '0;
      else if (stb)     gap_q <= CW'(1);
      else              gap_q <= gap_q + CW'(1);
   end

   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && shift_stb));

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> (!sample_stb && !shift_stb && sclk == cpol));

   a_r5_edge_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && $stable(cpol)) |-> (sclk != $past(sclk)));

   a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && act) |-> (gap_q == h_exp));

   a_r7_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);

   a_r7_shift_single: assert property (@(posedge clk) disable iff (!rst_n)
      shift_stb |=> !shift_stb);

endmodule

bind sclk_divider sclk_divider_chk #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_chk (.*);

// File: tb/sim_sclk_divider.sv
`timescale 1ns/1ps
module sim_sclk_divider;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, run = 1'b0, cpol = 1'b0, cpha = 1'b0;
   logic [7:0] presc = 8'd2, rate = 8'd0;
   logic       sclk, sample_stb, shift_stb;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #10 clk = ~clk;

   sclk_divider u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .run(run), .cpol(cpol), .cpha(cpha),
      .presc(presc), .rate(rate), .sclk(sclk),
      .sample_stb(sample_stb), .shift_stb(shift_stb)
   );

   function automatic int exp_half(input int p, input int r);
      int h;
      h = p / 2;
      if (h == 0) h = 1;
      return h * (r + 1);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Activate, observe 'edges' half periods, then drop activation.
   task automatic run_cfg(input int p, input int r, input bit pol, input bit pha,
                          input int edges, input string req);
      int  h;
      bit  stray;
      h = exp_half(p, r);
      @(negedge clk);
      presc = 8'(p); rate = 8'(r); cpol = pol; cpha = pha;
      en = 1'b1; run = 1'b1;
      stray = 0;
      for (int c = 1; c <= edges * h; c++) begin
         @(negedge clk);
         if (c % h == 0) begin
            int  j;
            bit  lead, exp_samp;
            j = c / h;
            lead = (j % 2) == 1;
            exp_samp = lead ? !pha : pha;
            // R6 edge type, R5 clock level, R3 timing
            check(sample_stb == exp_samp && shift_stb == !exp_samp,
                  {req, "/R6 strobe kind"}, {sample_stb, shift_stb}, {exp_samp, !exp_samp});
            check(sclk == (pol ^ lead), {req, "/R5 sclk level"}, sclk, pol ^ lead);
         end else if (sample_stb || shift_stb || sclk != (pol ^ ((c / h) % 2 == 1))) begin
            stray = 1;
         end
      end
      check(!stray, {req, "/R3 R7 no stray edge"}, stray, 0);
      run = 1'b0;
      @(negedge clk);
      check(!sample_stb && !shift_stb && sclk == pol, {req, "/R2 idle after run"},
            {sample_stb, shift_stb, sclk}, {2'b00, pol});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!sample_stb && !shift_stb && sclk == 1'b0, "R1 reset", {sample_stb, shift_stb, sclk}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!sample_stb && !shift_stb && sclk == 1'b0, "R1 after reset", {sample_stb, shift_stb, sclk}, 0);

      // R2 run without enable is ignored
      en = 1'b0; run = 1'b1; cpol = 1'b1; presc = 8'd2; rate = 8'd0;
      begin
         bit seen;
         seen = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sample_stb || shift_stb || sclk != 1'b1) seen = 1;
         end
         check(!seen, "R2 run while disabled", seen, 0);
      end
      run = 1'b0;

      // Directed corners
      run_cfg(2, 0, 0, 0, 6, "R3 fastest");
      run_cfg(0, 0, 1, 1, 4, "R4 presc0");
      run_cfg(1, 2, 0, 1, 4, "R4 presc1");
      run_cfg(3, 1, 1, 0, 4, "R4 odd3");
      run_cfg(7, 3, 0, 0, 4, "R4 odd7");
      run_cfg(254, 0, 1, 1, 2, "R3 max presc");
      run_cfg(255, 255, 0, 0, 1, "R3 R4 max divider");

      // R8 restart mid-bit
      begin
         int h;
         h = exp_half(6, 2);
         @(negedge clk);
         presc = 8'd6; rate = 8'd2; cpol = 0; cpha = 0; en = 1; run = 1;
         repeat (h + h / 2) @(negedge clk);
         run = 1'b0;
         @(negedge clk);
         check(sclk == 1'b0 && !sample_stb && !shift_stb, "R8 drop mid-bit", sclk, 0);
      end
      run_cfg(6, 2, 0, 0, 2, "R8 restart");

      // Constrained random
      begin
         void'($urandom(32'h5c1d_0042));
         for (int k = 0; k < 40; k++) begin
            run_cfg(int'($urandom_range(0, 31)), int'($urandom_range(0, 7)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 4, "R3 R6 random");
         end
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule